// File: doc/BRIEF.md
# Load/Store Address and Data Lane Unit

This unit sits between an execution pipeline and a data memory that is one 32-bit word wide. For each access it forms the effective address from a base register value and a signed 16-bit displacement. It rejects any address that is not on a 4-byte boundary. For stores it places the write data and byte enables on the memory request. For loads it records how the returned word must be shaped, then extracts and extends the data when the memory answers. Accesses narrower than a word always use the least-significant halfword or byte of the addressed word. The low address bits never select a lane, because a legal address has them at zero.

Requests enter on a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The pipeline must hold every request field stable while `req_valid` is high and `req_ready` is low. The memory request leaves through a one-entry output register on a second valid/ready pair. While `mem_ready` is low the register holds its content, and `req_ready` drops unless the register is empty. `req_ready` also drops while the tracker of outstanding loads is full. The memory returns read words in request order on `rsp_valid`, one word per issued load, and cannot be stalled. Shaped load data leaves on `ld_valid`/`ld_data`. The pipeline cannot stall this output either.

Top module: `lsu_lane_unit`

## Requirements
- R1: The memory address equals `req_base` plus `req_offset` sign-extended to 32 bits, so a displacement with bit 15 set lowers the address.
- R2: An accepted request whose effective address has bits [1:0] not equal to 00 issues no memory request, so its store writes nothing. `align_err` is high for exactly the one cycle after the acceptance edge.
- R3: A store with `req_size` 10 (word), or with the spare code 11, drives `mem_we`=1, `mem_be`=1111 and `mem_wdata` equal to `req_wdata`.
- R4: A store with `req_size` 01 (halfword) drives `mem_be`=0011 and `mem_wdata` = {16'h0, `req_wdata`[15:0]}.
- R5: A store with `req_size` 00 (byte) drives `mem_be`=0001 and `mem_wdata` = {24'h0, `req_wdata`[7:0]}.
- R6: A load (`req_write`=0) drives `mem_we`=0 and `mem_wdata`=0, with the same byte enables that a store of that size uses.
- R7: With `req_unsigned`=0, a byte load returns the returned word's bits [7:0] sign-extended from bit 7, and a halfword load returns bits [15:0] sign-extended from bit 15. A word load returns the word unchanged.
- R8: With `req_unsigned`=1, byte and halfword loads zero-extend the extracted bits.
- R9: `ld_valid` is high in the cycle after each cycle with `rsp_valid` high, and only then. Results come back in load request order.
- R10: While `mem_valid` is high and `mem_ready` is low, every memory request output holds its value. `req_ready` is high only when the output register is empty or being drained, and the load tracker has room.
- R11: During and right after reset, `mem_valid`, `align_err` and `ld_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can take the request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_unsigned | input | 1 | Zero-extend a narrow load instead of sign-extending |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 0 = least-significant byte |
| mem_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read word returned |
| rsp_rdata | input | 32 | Returned word |
| ld_valid | output | 1 | Shaped load result present |
| ld_data | output | 32 | Shaped load result |
| align_err | output | 1 | One-cycle misalignment pulse |

## Verification
The assertions rely on three properties of the memory. It answers only loads it has accepted, in the order it accepted them. It never answers more loads than were issued. Once a request is offered, the request is taken only through the valid/ready rule. The bench memory model builds its response queue only from read handshakes it has itself seen, and it releases each entry two cycles later. Its ready line follows a fixed pseudo-random pattern during the stall phase, so held requests and a full load tracker both occur without the model breaking the response order.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_SPARE = 2'b11
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      zext;
  } ld_fmt_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] disp,
  output logic [AW-1:0] eff_addr,
  output logic          misaligned
);
  logic [AW-1:0] disp_ext;

  always_comb begin
    disp_ext   = {{(AW-OW){disp[OW-1]}}, disp};
    eff_addr   = base + disp_ext;
    misaligned = |eff_addr[LANE_BITS-1:0];
  end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e        size,
  input  logic             is_write,
  input  logic [DW-1:0]    src,
  output logic [DW/8-1:0]  be,
  output logic [DW-1:0]    data
);
  localparam int NB = DW / 8;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        be   = NB'(1);
        data = DW'(src[7:0]);
      end
      SZ_HALF: begin
        be   = NB'(3);
        data = DW'(src[15:0]);
      end
      default: begin
        be   = '1;
        data = src;
      end
    endcase
    if (!is_write) data = '0;
  end
endmodule

// File: rtl/lsu_fmt_fifo.sv
module lsu_fmt_fifo
  import lsu_lane_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  ld_fmt_t push_fmt,
  input  logic    pop,
  output ld_fmt_t pop_fmt,
  output logic    full,
  output logic    empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ld_fmt_t       slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_fmt = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_fmt;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  ld_fmt_t       fmt,
  output logic [DW-1:0] shaped
);
  always_comb begin
    unique case (fmt.size)
      SZ_BYTE: shaped = fmt.zext ? DW'(raw[7:0])  : {{(DW-8){raw[7]}}, raw[7:0]};
      SZ_HALF: shaped = fmt.zext ? DW'(raw[15:0]) : {{(DW-16){raw[15]}}, raw[15:0]};
      default: shaped = raw;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int LD_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic            req_unsigned,
  input  logic [AW-1:0]   req_base,
  input  logic [OW-1:0]   req_offset,
  input  logic [DW-1:0]   req_wdata,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_rdata,
  output logic            ld_valid,
  output logic [DW-1:0]   ld_data,
  output logic            align_err
);
  localparam int NB = DW / 8;
  localparam int LANE_BITS = $clog2(NB);

  acc_size_e       size_in;
  logic [AW-1:0]   eff_addr;
  logic            misaligned;
  logic [NB-1:0]   pack_be;
  logic [DW-1:0]   pack_data;
  logic [DW-1:0]   shaped;
  ld_fmt_t         push_fmt, head_fmt;
  logic            trk_full, trk_empty;
  logic            accept, trk_push;

  assign size_in       = acc_size_e'(req_size);
  assign push_fmt.size = size_in;
  assign push_fmt.zext = req_unsigned;

  lsu_addr_gen #(.AW(AW), .OW(OW), .LANE_BITS(LANE_BITS)) u_addr (
    .base(req_base), .disp(req_offset), .eff_addr(eff_addr), .misaligned(misaligned)
  );

  lsu_store_pack #(.DW(DW)) u_pack (
    .size(size_in), .is_write(req_write), .src(req_wdata),
    .be(pack_be), .data(pack_data)
  );

  lsu_fmt_fifo #(.DEPTH(LD_DEPTH)) u_trk (
    .clk(clk), .rst_n(rst_n), .push(trk_push), .push_fmt(push_fmt),
    .pop(rsp_valid), .pop_fmt(head_fmt), .full(trk_full), .empty(trk_empty)
  );

  lsu_load_extract #(.DW(DW)) u_ext (
    .raw(rsp_rdata), .fmt(head_fmt), .shaped(shaped)
  );

  assign req_ready = (!mem_valid || mem_ready) && !trk_full;
  assign accept    = req_valid && req_ready;
  assign trk_push  = accept && !misaligned && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      align_err <= 1'b0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
    end else begin
      align_err <= accept && misaligned;
      if (accept) begin
        mem_valid <= !misaligned;
        mem_we    <= req_write;
        mem_addr  <= eff_addr;
        mem_be    <= pack_be;
        mem_wdata <= pack_data;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
      ld_valid <= rsp_valid;
      if (rsp_valid) ld_data <= shaped;
    end
  end

  assert_aligned_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[LANE_BITS-1:0] == '0));
  assert_err_no_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_valid);
  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_wdata) && $stable(mem_we)));
  assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_be == NB'(3)) |-> (mem_wdata[DW-1:16] == '0));
  assert_load_no_wdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_wdata == '0));
  assert_ld_follows_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(rsp_valid));
endmodule

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_offset = '0;
  logic        req_ready, mem_valid, mem_we, ld_valid, align_err;
  logic        mem_ready = 1'b1, rsp_valid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, rsp_rdata = '0, ld_data;
  logic [3:0]  mem_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .align_err(align_err)
  );

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
    string       tag;
  } exp_mem_t;
  typedef struct {
    int          due;
    logic [31:0] data;
  } rsp_t;

  logic [31:0] mem_arr [0:63];
  exp_mem_t    exp_mem_q[$];
  logic [2:0]  fmt_q[$];
  rsp_t        rsp_q[$];
  int          checks = 0, errors = 0, cyc = 0;
  logic        err_pend = 1'b0, ld_pend = 1'b0, held = 1'b0, stall_mode = 1'b0, done = 1'b0;
  logic [31:0] ld_exp = '0, held_addr = '0, held_wdata = '0;
  logic [3:0]  held_be = '0;
  logic        held_we = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string       ld_tag = "";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shape(input logic [31:0] w, input logic [1:0] sz, input logic u);
    if (sz == 2'b00) return u ? {24'h0, w[7:0]} : {{24{w[7]}}, w[7:0]};
    if (sz == 2'b01) return u ? {16'h0, w[15:0]} : {{16{w[15]}}, w[15:0]};
    return w;
  endfunction

  // memory model inputs, driven just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    if (rsp_q.size() > 0 && rsp_q[0].due <= cyc) begin
      rsp_valid = 1'b1;
      rsp_rdata = rsp_q[0].data;
      void'(rsp_q.pop_front());
    end else begin
      rsp_valid = 1'b0;
      rsp_rdata = '0;
    end
  end

  // reference model and comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!mem_valid && !align_err && !ld_valid, "R11 outputs idle in reset",
          {29'b0, mem_valid, align_err, ld_valid}, 32'h0);
    end else begin
      chk(align_err === err_pend, "R2 align_err pulse", {31'b0, align_err}, {31'b0, err_pend});
      chk(ld_valid === ld_pend, "R9 ld_valid timing", {31'b0, ld_valid}, {31'b0, ld_pend});
      if (ld_valid && ld_pend) chk(ld_data === ld_exp, ld_tag, ld_data, ld_exp);
      ld_pend = rsp_valid;
      if (rsp_valid) begin
        logic [2:0] f;
        f = fmt_q.pop_front();
        ld_exp = shape(rsp_rdata, f[2:1], f[0]);
        ld_tag = (f[2:1] == 2'b00 || f[2:1] == 2'b01) ? (f[0] ? "R8 zero-extended load" : "R7 sign-extended load")
                                                        : "R7 word load";
      end
      if (held) begin
        chk(mem_valid && mem_addr === held_addr && mem_be === held_be && mem_wdata === held_wdata
            && mem_we === held_we, "R10 held request stable", mem_addr, held_addr);
      end
      held = mem_valid && !mem_ready;
      held_addr = mem_addr; held_be = mem_be; held_wdata = mem_wdata; held_we = mem_we;
      if (mem_valid && mem_ready) begin
        if (exp_mem_q.size() == 0) begin
          chk(1'b0, "R2 unexpected memory request", mem_addr, 32'h0);
        end else begin
          exp_mem_t e;
          e = exp_mem_q.pop_front();
          chk(mem_addr === e.addr, "R1 effective address", mem_addr, e.addr);
          chk(mem_we === e.we, e.we ? "R3 write enable" : "R6 load write enable", {31'b0, mem_we}, {31'b0, e.we});
          chk(mem_be === e.be, e.tag, {28'b0, mem_be}, {28'b0, e.be});
          chk(mem_wdata === e.wdata, e.tag, mem_wdata, e.wdata);
          if (mem_we) begin
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem_arr[mem_addr[7:2]][8*b +: 8] = mem_wdata[8*b +: 8];
          end else begin
            rsp_q.push_back('{due: cyc + 2, data: mem_arr[mem_addr[7:2]]});
          end
        end
      end
      err_pend = 1'b0;
      if (req_valid && req_ready) begin
        logic [31:0] ea;
        exp_mem_t    n;
        ea = req_base + {{16{req_offset[15]}}, req_offset};
        if (ea[1:0] != 2'b00) begin
          err_pend = 1'b1;
        end else begin
          n.addr = ea;
          n.we = req_write;
          case (req_size)
            2'b00: begin n.be = 4'b0001; n.wdata = {24'h0, req_wdata[7:0]};  n.tag = "R5 byte lane"; end
            2'b01: begin n.be = 4'b0011; n.wdata = {16'h0, req_wdata[15:0]}; n.tag = "R4 halfword lane"; end
            default: begin n.be = 4'b1111; n.wdata = req_wdata; n.tag = "R3 word lanes"; end
          endcase
          if (!req_write) begin
            n.wdata = '0;
            n.tag = "R6 load request";
            fmt_q.push_back({req_size, req_unsigned});
          end
          exp_mem_q.push_back(n);
        end
      end
    end
  end

  task automatic do_req(input logic w, input logic [1:0] sz, input logic u,
                        input logic [31:0] base, input logic [15:0] off, input logic [31:0] wd);
    req_valid = 1'b1; req_write = w; req_size = sz; req_unsigned = u;
    req_base = base; req_offset = off; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_arr[i] = 32'h9E3779B1 * (i + 1) ^ 32'h0080_8000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 req_ready after reset", {31'b0, req_ready}, 32'h1);
    @(posedge clk); #1;
    // directed
    do_req(1, 2'b10, 0, 32'h0000_1000, 16'h0010, 32'hDEAD_BEEF);   // word store R3
    do_req(0, 2'b10, 0, 32'h0000_1020, 16'hFFF0, 32'h0);           // word load, negative offset R1
    do_req(1, 2'b01, 0, 32'h0000_1004, 16'h0000, 32'h1234_F678);   // half store R4
    do_req(0, 2'b01, 0, 32'h0000_1004, 16'h0000, 32'h0);           // signed half R7
    do_req(0, 2'b01, 1, 32'h0000_1004, 16'h0000, 32'h0);           // unsigned half R8
    do_req(1, 2'b00, 0, 32'h0000_1010, 16'hFFF8, 32'hAAAA_AA9C);   // byte store, negative R5
    do_req(0, 2'b00, 0, 32'h0000_1008, 16'h0000, 32'h0);           // signed byte R7
    do_req(0, 2'b00, 1, 32'h0000_1008, 16'h0000, 32'h0);           // unsigned byte R8
    do_req(1, 2'b10, 0, 32'h0000_1000, 16'h0012, 32'h0BAD_0BAD);   // misaligned store R2
    do_req(0, 2'b10, 0, 32'h0000_1010, 16'h0000, 32'h0);           // still DEADBEEF R2
    do_req(0, 2'b00, 0, 32'h0000_1003, 16'h0000, 32'h0);           // misaligned load R2
    do_req(1, 2'b11, 0, 32'h0000_1018, 16'h0000, 32'h5555_1234);   // spare size as word R3
    do_req(0, 2'b11, 1, 32'h0000_1018, 16'h0000, 32'h0);
    // mixed traffic with memory back-pressure R10
    stall_mode = 1'b1;
    for (int i = 0; i < 80; i++) begin
      logic [15:0] off;
      off = (i % 5 == 0) ? 16'hFFF8 : 16'(4 * (i % 7));
      if (i % 11 == 3) off = off + 16'd2;
      do_req((i % 3) == 0, 2'(i % 4), (i >> 1) & 1, 32'h0000_2000 + 32'(4 * (i % 16)), off,
             32'h8181_8181 ^ 32'(i * 32'h0101_0137));
    end
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_mem_q.size() == 0 && fmt_q.size() == 0, "R9 all requests and loads completed",
        32'(exp_mem_q.size() + fmt_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule